// File: doc/BRIEF.md
# Dual Bitstream Multiplexer and Configuration Decoder

This block is the digital front end of a two-channel 1-bit sigma-delta converter. Two modulator bitstreams arrive as bit inputs, one for the voltage channel and one for the current channel. The block interleaves them by the phase of an external measurement clock onto a single serial output and its complement, so one pin pair carries both channels.

All logic runs on a fast system clock, and the measurement clock is sampled as a level. The block detects its edges and derives these signals from them:
- a sample strobe at half the measurement rate;
- two non-overlapping conversion phases;
- a voltage-channel chopper;
- a complementary pair of current-channel choppers.

Two configuration pins are decoded. The gain pin picks the current-channel amplification. The reference pin is classified four ways: held low, held high, following the measurement clock, or following its inverse. Its code is committed only after it has stayed the same for several measurement periods. The code drives a prescaler request, and the first commit after reset enables the voltage channel. The active-low power-on reset blocks every function.

Top module: `sdm_dual_frontend`

## Requirements
- R1: One system cycle after a sample, `dat_o` equals `bs_v_i` if `mclk_i` was high at that sample and `bs_c_i` if it was low.
- R2: `dat_n_o` is always the inverse of `dat_o`, including during reset.
- R3: While `rst_ni` is low, the following outputs are 0: `dat_o`, `strobe_o`, both phases, `vchop_o`, `cchop_o`, `gain32_o`, `tc_code_o`, `prescale_o` and `vch_en_o`. `dat_n_o` and `cchop_n_o` are 1.
- R4: `strobe_o` is a one-cycle pulse on every second rising edge of `mclk_i`. The first pulse comes on the second rising edge after reset.
- R5: `phi_a_o` follows the high phase of odd measurement periods and `phi_b_o` the high phase of even ones, counted from reset. The two are never high together.
- R6: `vchop_o` toggles with every strobe. `cchop_o` toggles on every second strobe, and `cchop_n_o` is always its inverse.
- R7: `gain32_o` follows `gain_sel_i` one cycle later. 0 selects gain 8 and 1 selects gain 32.
- R8: The reference pin is sampled at each rising and each falling edge of `mclk_i`, and each measurement period is classified as one code. Code 0 means the pin is low at both edges. Code 1 means it is high at the rising edge and low at the falling edge, so it follows the clock. Code 2 means the reverse, so it follows the inverted clock. Code 3 means it is high at both edges. The committed code appears on `tc_code_o`.
- R9: A classification is made at each falling edge. A new code is committed only when 4 consecutive classifications agree, and any different classification restarts the count.
- R10: `prescale_o` is 1 exactly when the committed code is 1 or 2. `vch_en_o` rises at the first commit after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| mclk_i | input | 1 | Measurement clock level, synchronous to clk_i |
| gain_sel_i | input | 1 | Current-channel gain select pin |
| tc_sel_i | input | 1 | Reference coefficient select pin |
| bs_v_i | input | 1 | Voltage-channel modulator bit |
| bs_c_i | input | 1 | Current-channel modulator bit |
| dat_o | output | 1 | Interleaved bitstream |
| dat_n_o | output | 1 | Inverse of dat_o |
| strobe_o | output | 1 | Modulator sample strobe |
| phi_a_o | output | 1 | Conversion phase A |
| phi_b_o | output | 1 | Conversion phase B |
| vchop_o | output | 1 | Voltage-channel chopper |
| cchop_o | output | 1 | Current-channel chopper |
| cchop_n_o | output | 1 | Complement current-channel chopper |
| gain32_o | output | 1 | 1 = gain 32, 0 = gain 8 |
| tc_code_o | output | 2 | Committed reference coefficient code |
| prescale_o | output | 1 | Prescaler halving request |
| vch_en_o | output | 1 | Voltage-channel enable |

## Verification
The falling edge of the measurement clock that completes the fourth matching classification also switches `dat_o` from the voltage bit to the current bit, so the commit and the interleave change fall in the same cycle. The bench holds opposite values on the two bitstreams while it steps the reference pin through each pattern. At the end of every low phase it compares both `dat_o` and `tc_code_o` with values worked out from the number of measurement periods applied. It also interrupts a run of matching classifications with one period of a different pattern and confirms that no commit happens early.

// File: rtl/sdfe_pkg.sv
package sdfe_pkg;
  typedef enum logic [1:0] {
    TC_LOW  = 2'd0,
    TC_TRUE = 2'd1,
    TC_INV  = 2'd2,
    TC_HIGH = 2'd3
  } tc_code_e;
endpackage

// File: rtl/sdfe_clkgen.sv
module sdfe_clkgen #(
  parameter int unsigned CCHOP_SPAN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  output logic rise_o,
  output logic fall_o,
  output logic strobe_o,
  output logic phi_a_o,
  output logic phi_b_o,
  output logic vchop_o,
  output logic cchop_o,
  output logic cchop_n_o
);
  localparam int unsigned CW = (CCHOP_SPAN > 1) ? $clog2(CCHOP_SPAN) : 1;
  localparam logic [CW-1:0] SPAN_LAST = CW'(CCHOP_SPAN - 1);

  logic          mclk_q;
  logic          tgl_q, tgl_n;
  logic          strobe_n;
  logic          strobe_q, phi_a_q, phi_b_q;
  logic          vchop_q, cchop_q, cchop_n_q;
  logic [CW-1:0] span_q;

  assign rise_o   = mclk_i & ~mclk_q;
  assign fall_o   = ~mclk_i & mclk_q;
  assign tgl_n    = rise_o ? ~tgl_q : tgl_q;
  assign strobe_n = rise_o & tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q    <= 1'b0;
      tgl_q     <= 1'b0;
      strobe_q  <= 1'b0;
      phi_a_q   <= 1'b0;
      phi_b_q   <= 1'b0;
      vchop_q   <= 1'b0;
      cchop_q   <= 1'b0;
      cchop_n_q <= 1'b1;
      span_q    <= '0;
    end else begin
      mclk_q   <= mclk_i;
      tgl_q    <= tgl_n;
      strobe_q <= strobe_n;
      phi_a_q  <= mclk_i & tgl_n;
      phi_b_q  <= mclk_i & ~tgl_n;
      if (strobe_n) begin
        vchop_q <= ~vchop_q;
        if (span_q == SPAN_LAST) begin
          span_q    <= '0;
          cchop_q   <= ~cchop_q;
          cchop_n_q <= cchop_q;
        end else begin
          span_q <= span_q + 1'b1;
        end
      end
    end
  end

  assign strobe_o  = strobe_q;
  assign phi_a_o   = phi_a_q;
  assign phi_b_o   = phi_b_q;
  assign vchop_o   = vchop_q;
  assign cchop_o   = cchop_q;
  assign cchop_n_o = cchop_n_q;

  // R5
  phase_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi_a_q && phi_b_q));
  // R4
  strobe_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> $rose(phi_b_q));
  // R6
  cchop_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cchop_q != cchop_n_q);
  // R6
  vchop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vchop_q != $past(vchop_q)) |-> strobe_q);
endmodule

// File: rtl/sdfe_mode_dec.sv
module sdfe_mode_dec
  import sdfe_pkg::*;
#(
  parameter int unsigned STABLE_CNT = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rise_i,
  input  logic     fall_i,
  input  logic     gain_sel_i,
  input  logic     tc_sel_i,
  output tc_code_e tc_code_o,
  output logic     gain32_o,
  output logic     prescale_o,
  output logic     vch_en_o
);
  localparam int unsigned CNTW = $clog2(STABLE_CNT + 1);
  localparam logic [CNTW-1:0] CNT_TOP = CNTW'(STABLE_CNT);

  logic            hi_smp_q, hi_vld_q;
  tc_code_e        cls, cand_q, code_q;
  logic [CNTW-1:0] cnt_q, cnt_nxt;
  logic            cls_evt, commit;
  logic            gain_q, lock_q;

  always_comb begin
    unique case ({hi_smp_q, tc_sel_i})
      2'b00:   cls = TC_LOW;
      2'b10:   cls = TC_TRUE;
      2'b01:   cls = TC_INV;
      default: cls = TC_HIGH;
    endcase
  end

  assign cls_evt = fall_i & hi_vld_q;

  always_comb begin
    if (cls != cand_q)        cnt_nxt = CNTW'(1);
    else if (cnt_q == CNT_TOP) cnt_nxt = cnt_q;
    else                      cnt_nxt = cnt_q + 1'b1;
  end

  assign commit = cls_evt && (cnt_nxt >= CNT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_smp_q <= 1'b0;
      hi_vld_q <= 1'b0;
      cand_q   <= TC_LOW;
      code_q   <= TC_LOW;
      cnt_q    <= '0;
      gain_q   <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      gain_q <= gain_sel_i;
      if (rise_i) begin
        hi_smp_q <= tc_sel_i;
        hi_vld_q <= 1'b1;
      end
      if (cls_evt) begin
        cand_q <= cls;
        cnt_q  <= cnt_nxt;
      end
      if (commit) begin
        code_q <= cls;
        lock_q <= 1'b1;
      end
    end
  end

  assign tc_code_o  = code_q;
  assign gain32_o   = gain_q;
  assign prescale_o = (code_q == TC_TRUE) || (code_q == TC_INV);
  assign vch_en_o   = lock_q;

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cls_evt |=> $stable(code_q));
  // R9
  commit_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> (cnt_q == CNT_TOP));
  // R10
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  // R7
  gain_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (gain_q == $past(gain_sel_i)));
endmodule

// File: rtl/sdfe_bitmux.sv
module sdfe_bitmux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  input  logic bs_v_i,
  input  logic bs_c_i,
  output logic dat_o,
  output logic dat_n_o
);
  logic dat_q, dat_n_q, sel_bit;

  assign sel_bit = mclk_i ? bs_v_i : bs_c_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q   <= 1'b0;
      dat_n_q <= 1'b1;
    end else begin
      dat_q   <= sel_bit;
      dat_n_q <= ~sel_bit;
    end
  end

  assign dat_o   = dat_q;
  assign dat_n_o = dat_n_q;

  // R2
  dat_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_q != dat_n_q);
  // R1
  dat_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dat_q == ($past(mclk_i) ? $past(bs_v_i) : $past(bs_c_i))));
endmodule

// File: rtl/sdm_dual_frontend.sv
module sdm_dual_frontend #(
  parameter int unsigned STABLE_CNT = 4,
  parameter int unsigned CCHOP_SPAN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       gain_sel_i,
  input  logic       tc_sel_i,
  input  logic       bs_v_i,
  input  logic       bs_c_i,
  output logic       dat_o,
  output logic       dat_n_o,
  output logic       strobe_o,
  output logic       phi_a_o,
  output logic       phi_b_o,
  output logic       vchop_o,
  output logic       cchop_o,
  output logic       cchop_n_o,
  output logic       gain32_o,
  output logic [1:0] tc_code_o,
  output logic       prescale_o,
  output logic       vch_en_o
);
  import sdfe_pkg::*;

  logic     rise, fall;
  tc_code_e code;

  sdfe_clkgen #(.CCHOP_SPAN(CCHOP_SPAN)) u_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mclk_i   (mclk_i),
    .rise_o   (rise),
    .fall_o   (fall),
    .strobe_o (strobe_o),
    .phi_a_o  (phi_a_o),
    .phi_b_o  (phi_b_o),
    .vchop_o  (vchop_o),
    .cchop_o  (cchop_o),
    .cchop_n_o(cchop_n_o)
  );

  sdfe_mode_dec #(.STABLE_CNT(STABLE_CNT)) u_mode_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .fall_i    (fall),
    .gain_sel_i(gain_sel_i),
    .tc_sel_i  (tc_sel_i),
    .tc_code_o (code),
    .gain32_o  (gain32_o),
    .prescale_o(prescale_o),
    .vch_en_o  (vch_en_o)
  );

  sdfe_bitmux u_bitmux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mclk_i (mclk_i),
    .bs_v_i (bs_v_i),
    .bs_c_i (bs_c_i),
    .dat_o  (dat_o),
    .dat_n_o(dat_n_o)
  );

  assign tc_code_o = code;
endmodule

// File: tb/sdm_dual_frontend_tb_top.sv
`timescale 1ns/1ps
module sdm_dual_frontend_tb_top;
  localparam int H = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mclk_i = 1'b0, gain_sel_i = 1'b0, tc_sel_i = 1'b0;
  logic bs_v_i = 1'b1, bs_c_i = 1'b0;
  logic dat_o, dat_n_o, strobe_o, phi_a_o, phi_b_o, vchop_o, cchop_o, cchop_n_o;
  logic gain32_o, prescale_o, vch_en_o;
  logic [1:0] tc_code_o;

  int checks = 0, fails = 0;
  bit done = 0;

  bit mon_en = 0;
  int n_strb, n_vt, n_ct, n_ovl, n_pair, n_pa, n_pb;
  logic vprev, cprev;

  always #4 clk_i = ~clk_i;

  sdm_dual_frontend dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mclk_i(mclk_i), .gain_sel_i(gain_sel_i),
    .tc_sel_i(tc_sel_i), .bs_v_i(bs_v_i), .bs_c_i(bs_c_i), .dat_o(dat_o),
    .dat_n_o(dat_n_o), .strobe_o(strobe_o), .phi_a_o(phi_a_o), .phi_b_o(phi_b_o),
    .vchop_o(vchop_o), .cchop_o(cchop_o), .cchop_n_o(cchop_n_o),
    .gain32_o(gain32_o), .tc_code_o(tc_code_o), .prescale_o(prescale_o),
    .vch_en_o(vch_en_o)
  );

  always @(negedge clk_i) begin
    if (mon_en) begin
      if (strobe_o) n_strb++;
      if (vchop_o != vprev) n_vt++;
      if (cchop_o != cprev) n_ct++;
      if (phi_a_o && phi_b_o) n_ovl++;
      if (cchop_o == cchop_n_o) n_pair++;
      if (phi_a_o) n_pa++;
      if (phi_b_o) n_pb++;
      vprev = vchop_o;
      cprev = cchop_o;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    n_strb = 0; n_vt = 0; n_ct = 0; n_ovl = 0; n_pair = 0; n_pa = 0; n_pb = 0;
    vprev = vchop_o; cprev = cchop_o;
    mon_en = 1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; mclk_i = 1'b0; tc_sel_i = 1'b0;
    #1;
    chk("R3 dat", dat_o, 0);
    chk("R3 dat_n", dat_n_o, 1);
    chk("R3 code", tc_code_o, 0);
    chk("R3 gain", gain32_o, 0);
    chk("R3 strobe/phase", {strobe_o, phi_a_o, phi_b_o}, 0);
    chk("R3 choppers", {vchop_o, cchop_o, cchop_n_o}, 1);
    chk("R3 prescale/vch_en", {prescale_o, vch_en_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // entered and left at a negedge; one measurement period
  task automatic run_period(input int pat);
    mclk_i = 1'b1; tc_sel_i = (pat == 1 || pat == 3);
    repeat (H) @(negedge clk_i);
    chk("R1 high phase carries voltage bit", dat_o, bs_v_i);
    chk("R2 complement", dat_n_o, !dat_o);
    mclk_i = 1'b0; tc_sel_i = (pat == 2 || pat == 3);
    repeat (H) @(negedge clk_i);
    chk("R1 low phase carries current bit", dat_o, bs_c_i);
  endtask

  task automatic test_first_commit();
    do_reset();
    for (int i = 0; i < 3; i++) run_period(3);
    chk("R9 no commit after 3", tc_code_o, 0);
    chk("R10 vch_en before commit", vch_en_o, 0);
    run_period(3);
    chk("R8 static high code", tc_code_o, 3);
    chk("R10 vch_en after commit", vch_en_o, 1);
    chk("R10 prescale code3", prescale_o, 0);
  endtask

  task automatic test_timing_gen();
    do_reset();
    mon_clear();
    run_period(0);
    chk("R4 no strobe on first rise", n_strb, 0);
    chk("R5 phase A first period", n_pa, H);
    chk("R5 phase B first period", n_pb, 0);
    for (int i = 0; i < 7; i++) run_period(0);
    mon_en = 0;
    chk("R4 strobes over 8 periods", n_strb, 4);
    chk("R5 phase A cycles", n_pa, 4 * H);
    chk("R5 phase B cycles", n_pb, 4 * H);
    chk("R5 overlap", n_ovl, 0);
    chk("R6 vchop toggles", n_vt, 4);
    chk("R6 cchop toggles", n_ct, 2);
    chk("R6 cchop pair", n_pair, 0);
  endtask

  task automatic test_mode_walk();
    for (int i = 0; i < 4; i++) run_period(1);
    chk("R8 true-clock code", tc_code_o, 1);
    chk("R10 prescale code1", prescale_o, 1);
    for (int i = 0; i < 3; i++) run_period(2);
    chk("R9 hold code1", tc_code_o, 1);
    run_period(2);
    chk("R8 inverted-clock code", tc_code_o, 2);
    chk("R10 prescale code2", prescale_o, 1);
    for (int i = 0; i < 4; i++) run_period(0);
    chk("R8 static low code", tc_code_o, 0);
    chk("R10 prescale code0", prescale_o, 0);
  endtask

  task automatic test_interrupt();
    bs_v_i = 1'b0; bs_c_i = 1'b1;
    for (int i = 0; i < 3; i++) run_period(3);
    run_period(1);
    for (int i = 0; i < 3; i++) run_period(3);
    chk("R9 interrupted run held", tc_code_o, 0);
    run_period(3);
    chk("R9 commit after fresh run", tc_code_o, 3);
    bs_v_i = 1'b1; bs_c_i = 1'b0;
  endtask

  task automatic test_gain();
    gain_sel_i = 1'b1;
    @(negedge clk_i);
    chk("R7 gain32", gain32_o, 1);
    gain_sel_i = 1'b0;
    @(negedge clk_i);
    chk("R7 gain8", gain32_o, 0);
  endtask

  task automatic test_mux();
    for (int k = 0; k < 8; k++) begin
      mclk_i = k[2]; bs_v_i = k[1]; bs_c_i = k[0];
      @(negedge clk_i);
      chk("R1 mux", dat_o, k[2] ? k[1] : k[0]);
      chk("R2 mux complement", dat_n_o, k[2] ? !k[1] : !k[0]);
    end
    mclk_i = 1'b0; bs_v_i = 1'b1; bs_c_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic test_reset_midrun();
    mclk_i = 1'b1; bs_v_i = 1'b1;
    @(negedge clk_i);
    chk("R1 pre-reset dat", dat_o, 1);
    do_reset();
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    test_first_commit();
    test_timing_gen();
    test_mode_walk();
    test_interrupt();
    test_gain();
    test_mux();
    test_reset_midrun();
    chk("R3 code after release", tc_code_o, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule